// File: doc/BRIEF.md
# Dynamic bus sizing controller

This block connects a 32-bit internal operand path to an external data bus whose port may be 8, 16 or 32 bits wide. A request carries an operand of one to four bytes, a start address, a direction and a cachable flag. The block then runs one or more bus cycles. In each cycle it presents a size code for the bytes still owed and the current address. It waits for the port to report its width on a two-bit acknowledge. It then advances by the number of bytes that port accepted, until nothing is left.

Narrow ports hang off the most-significant lanes. On writes the block places each remaining operand byte on every lane that any port width could read for the current address, so the data is already right before the width is known. On reads it picks the accepted bytes off their lanes and builds a right-justified operand. For cachable reads it also hands out every lane of the reported port as a valid fill, including neighbours of the operand.

Top module: `dyn_bus_sizer`

## Requirements
- R1: `bus_size_code` shows the bytes still to transfer: 01 = one, 10 = two, 11 = three, 00 = four; `req_size` uses the same encoding for the operand length.
- R2: `bus_addr` equals the request address plus the bytes already transferred, so its two low bits are the byte offset within the long word.
- R3: `bus_ack` 00 is a wait that leaves the cycle, address and size code unchanged; 01, 10 and 11 end the cycle for an 8-, 16- and 32-bit port.
- R4: Lanes are numbered 0 to 3, with lane 0 on bits 31:24. A cycle moves min(remaining, port bytes minus offset within the port) bytes, where the offset is A1:A0 for a 32-bit port, A0 for a 16-bit port and zero for an 8-bit port. The byte at the current address sits on that lane, and the following bytes sit on the lanes after it.
- R5: On writes, for every possible port width, each lane that the width would use for the current address and remaining count carries the correct operand byte (operand byte 0 is the most significant, i.e. `req_wdata` bits [8n-1:8n-8] for an n-byte operand).
- R6: A completed read yields `rd_data` with the first transferred byte most significant, right-justified, and unused upper bytes zero.
- R7: On a noncachable read, lanes outside the accepted bytes do not affect `rd_data`.
- R8: One clock after each acknowledged cachable read cycle, `fill_valid` pulses. `fill_addr` gives the long-word-aligned address. `fill_mask` bit k marks memory byte k of that long word as supplied by the port's lanes, and `fill_data` holds byte k at bits [31-8k:24-8k], with unmarked bytes zero.
- R9: `done` pulses for one clock in the cycle after the final acknowledge, with `bus_cycle` low; `rd_data` holds until the next request is accepted.
- R10: A request is taken only while idle; `req_valid` during a transfer has no effect.
- R11: After reset, `bus_cycle`, `done` and `fill_valid` are low and `rd_data` is zero.
- R12: `bus_cachable` is high only during read cycles of a cachable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a transfer (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand length code |
| req_addr | input | ADDR_W | Operand start address |
| req_wdata | input | 32 | Write operand, right-justified |
| req_cachable | input | 1 | Read may be cached |
| bus_ack | input | 2 | Port-width acknowledge / wait |
| bus_rdata | input | 32 | Read data lanes |
| bus_cycle | output | 1 | Bus cycle in progress |
| bus_size_code | output | 2 | Bytes remaining code |
| bus_addr | output | ADDR_W | Current cycle address |
| bus_write | output | 1 | Cycle direction |
| bus_wdata | output | 32 | Steered and duplicated write lanes |
| bus_cachable | output | 1 | Cachable read cycle |
| done | output | 1 | Transfer complete pulse |
| rd_data | output | 32 | Assembled read operand |
| fill_valid | output | 1 | Cache fill pulse |
| fill_addr | output | ADDR_W | Aligned fill address |
| fill_mask | output | 4 | Valid bytes of fill, bit k = byte k |
| fill_data | output | 32 | Fill bytes in memory order |

## Verification
The bench sweeps every operand length against every start offset. It does this with fixed 8-, 16- and 32-bit ports and with ports that change width from cycle to cycle. It adds waits and stray requests during transfers. Misaligned long words are the sharpest case. A controller that subtracts the full port width instead of the bytes left in the port would skip or repeat bytes, and that shows as a wrong address, a wrong size code or a corrupt memory image. On writes it checks the lanes of all three widths every cycle, so duplication that only suits the actually acknowledged width is caught. On reads it drives garbage on lanes that do not belong to the accepted bytes, which exposes gathering from the wrong lane. On cachable reads it checks that the fill mask covers every lane of the port and not just the requested bytes.

// File: rtl/dbs_pkg.sv
// Shared definitions for the dynamic bus sizing controller.
// Assumes a 32-bit operand path split into four byte lanes, lane 0 on bits 31:24.
package dbs_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int OP_W   = LANES * LANE_W;

    // Port width acknowledge codes
    typedef enum logic [1:0] {
        ACK_WAIT = 2'b00,
        ACK_P8   = 2'b01,
        ACK_P16  = 2'b10,
        ACK_P32  = 2'b11
    } ack_e;

    // Size code to byte count; code 00 means four bytes
    function automatic logic [2:0] code_to_count(input logic [1:0] code);
        return (code == 2'b00) ? 3'd4 : {1'b0, code};
    endfunction

    // Bytes a port can take starting at the given long-word offset
    function automatic logic [2:0] port_room(input ack_e ack, input logic [1:0] off);
        case (ack)
            ACK_P32: return 3'd4 - {1'b0, off};
            ACK_P16: return 3'd2 - {2'b00, off[0]};
            ACK_P8:  return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    // First lane used by a port for the given long-word offset
    function automatic logic [1:0] port_first_lane(input ack_e ack, input logic [1:0] off);
        case (ack)
            ACK_P32: return off;
            ACK_P16: return {1'b0, off[0]};
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/dbs_sequencer.sv
// Transfer sequencer: accepts a request when idle, keeps the remaining byte
// count and current address, and retires bytes on each non-wait acknowledge.
// Assumes bus_ack is only meaningful while a cycle is in progress.
module dbs_sequencer
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [OP_W-1:0]   req_wdata,
    input  logic              req_cachable,
    input  logic [1:0]        bus_ack,
    output logic              busy,
    output logic              start,
    output logic              advance,
    output logic [2:0]        step_bytes,
    output logic [1:0]        first_lane,
    output logic [2:0]        remaining,
    output logic [2:0]        op_count,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              op_write,
    output logic [OP_W-1:0]   op_wdata,
    output logic              op_cachable,
    output logic              done
);

    ack_e       ack;
    logic [2:0] room;
    logic       last;

    // Decode acknowledge and work out how many bytes this cycle retires
    always_comb begin
        ack        = ack_e'(bus_ack);
        room       = port_room(ack, cur_addr[1:0]);
        first_lane = port_first_lane(ack, cur_addr[1:0]);
        step_bytes = (remaining < room) ? remaining : room;
        start      = req_valid && !busy;
        advance    = busy && (ack != ACK_WAIT);
        last       = advance && (step_bytes == remaining);
    end

    // Request capture, count and address bookkeeping, completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            remaining   <= 3'd0;
            op_count    <= 3'd0;
            cur_addr    <= '0;
            op_write    <= 1'b0;
            op_wdata    <= '0;
            op_cachable <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= last;
            if (start) begin
                busy        <= 1'b1;
                remaining   <= code_to_count(req_size);
                op_count    <= code_to_count(req_size);
                cur_addr    <= req_addr;
                op_write    <= req_write;
                op_wdata    <= req_wdata;
                op_cachable <= req_cachable;
            end else if (advance) begin
                remaining <= remaining - step_bytes;
                cur_addr  <= cur_addr + ADDR_W'(step_bytes);
                if (last) begin
                    busy <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/dbs_write_lanes.sv
// Write lane steering: places the next operand bytes on every lane that an
// 8-, 16- or 32-bit port could read at the current offset, so the lanes are
// correct before the port width is known. Lanes past the operand end are zero.
module dbs_write_lanes
    import dbs_pkg::*;
(
    input  logic [2:0]      op_count,
    input  logic [2:0]      remaining,
    input  logic [1:0]      offset,
    input  logic [OP_W-1:0] op_wdata,
    output logic [OP_W-1:0] lane_data
);

    logic [2:0] sent;

    // Bytes already moved decide which operand byte is next
    always_comb begin
        sent = op_count - remaining;
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [1:0]      rel;
        logic [2:0]      idx;
        logic [2:0]      shift_bytes;
        logic [OP_W-1:0] shifted;

        // Pick the operand byte this lane must carry for the current offset
        always_comb begin
            case (offset)
                2'd0:    rel = 2'(ln);
                2'd1:    rel = (ln == 0) ? 2'd0 : 2'(ln - 1);
                2'd2:    rel = 2'(ln % 2);
                default: rel = 2'd0;
            endcase
            idx         = sent + {1'b0, rel};
            shift_bytes = op_count - 3'd1 - idx;
            shifted     = op_wdata >> {shift_bytes, 3'b000};
            lane_data[OP_W-1-LANE_W*ln -: LANE_W] =
                (idx < op_count) ? shifted[LANE_W-1:0] : '0;
        end
    end

endmodule

// File: rtl/dbs_read_assemble.sv
// Read assembly: on each acknowledged read cycle, copies the accepted bytes
// from their lanes into a right-justified operand register. Lanes outside the
// accepted bytes are never sampled. Cleared when a new request starts.
module dbs_read_assemble
    import dbs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            advance,
    input  logic            op_write,
    input  logic [2:0]      op_count,
    input  logic [2:0]      remaining,
    input  logic [2:0]      step_bytes,
    input  logic [1:0]      first_lane,
    input  logic [OP_W-1:0] bus_rdata,
    output logic [OP_W-1:0] rd_data
);

    logic [OP_W-1:0] asm_next;
    logic [2:0]      sent;

    // Compute the operand with this cycle's accepted bytes merged in
    always_comb begin
        sent     = op_count - remaining;
        asm_next = rd_data;
        for (int i = 0; i < LANES; i++) begin
            int src_lane;
            int dst_pos;
            src_lane = int'(first_lane) + i;
            dst_pos  = int'(op_count) - 1 - int'(sent) - i;
            if ((3'(i) < step_bytes) && (dst_pos >= 0) && (src_lane < LANES)) begin
                asm_next[LANE_W*dst_pos +: LANE_W] =
                    bus_rdata[LANE_W*(LANES-1-src_lane) +: LANE_W];
            end
        end
    end

    // Hold the operand register; clear on start, update on read acknowledges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (start) begin
            rd_data <= '0;
        end else if (advance && !op_write) begin
            rd_data <= asm_next;
        end
    end

endmodule

// File: rtl/dbs_fill_capture.sv
// Cache fill capture: after each acknowledged cachable read cycle, reports
// every byte the port drove (operand and neighbours) in long-word memory
// order with a per-byte valid mask. Assumes narrow ports sit on upper lanes.
module dbs_fill_capture
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              op_write,
    input  logic              op_cachable,
    input  logic [1:0]        bus_ack,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [OP_W-1:0]   bus_rdata,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [LANES-1:0]  fill_mask,
    output logic [OP_W-1:0]   fill_data
);

    logic [LANES-1:0] mask_d;
    logic [OP_W-1:0]  data_d;

    for (genvar k = 0; k < LANES; k++) begin : g_byte
        logic       hit;
        logic [1:0] lane;

        // Find whether memory byte k arrived, and on which lane
        always_comb begin
            case (ack_e'(bus_ack))
                ACK_P32: begin
                    hit  = 1'b1;
                    lane = 2'(k);
                end
                ACK_P16: begin
                    hit  = (1'(k / 2) == cur_addr[1]);
                    lane = 2'(k % 2);
                end
                ACK_P8: begin
                    hit  = (2'(k) == cur_addr[1:0]);
                    lane = 2'd0;
                end
                default: begin
                    hit  = 1'b0;
                    lane = 2'd0;
                end
            endcase
            mask_d[k] = hit;
            data_d[OP_W-1-LANE_W*k -: LANE_W] =
                hit ? bus_rdata[LANE_W*(LANES-1-int'(lane)) +: LANE_W] : '0;
        end
    end

    // Register the fill report for one clock after a cachable read cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_valid <= 1'b0;
            fill_addr  <= '0;
            fill_mask  <= '0;
            fill_data  <= '0;
        end else begin
            fill_valid <= advance && !op_write && op_cachable;
            if (advance && !op_write && op_cachable) begin
                fill_addr <= {cur_addr[ADDR_W-1:2], 2'b00};
                fill_mask <= mask_d;
                fill_data <= data_d;
            end
        end
    end

endmodule

// File: rtl/dyn_bus_sizer.sv
// Dynamic bus sizing controller top: splits one operand transfer into bus
// cycles sized to the port width the acknowledge reports, steers write lanes,
// gathers read lanes and reports cachable fills. Synchronous active-low reset.
module dyn_bus_sizer
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              req_cachable,
    input  logic [1:0]        bus_ack,
    input  logic [31:0]       bus_rdata,
    output logic              bus_cycle,
    output logic [1:0]        bus_size_code,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [31:0]       bus_wdata,
    output logic              bus_cachable,
    output logic              done,
    output logic [31:0]       rd_data,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [3:0]        fill_mask,
    output logic [31:0]       fill_data
);

    logic              busy;
    logic              start;
    logic              advance;
    logic [2:0]        step_bytes;
    logic [1:0]        first_lane;
    logic [2:0]        remaining;
    logic [2:0]        op_count;
    logic [ADDR_W-1:0] cur_addr;
    logic              op_write;
    logic [OP_W-1:0]   op_wdata;
    logic              op_cachable;

    dbs_sequencer #(.ADDR_W(ADDR_W)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_size     (req_size),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_cachable (req_cachable),
        .bus_ack      (bus_ack),
        .busy         (busy),
        .start        (start),
        .advance      (advance),
        .step_bytes   (step_bytes),
        .first_lane   (first_lane),
        .remaining    (remaining),
        .op_count     (op_count),
        .cur_addr     (cur_addr),
        .op_write     (op_write),
        .op_wdata     (op_wdata),
        .op_cachable  (op_cachable),
        .done         (done)
    );

    dbs_write_lanes wr_i (
        .op_count  (op_count),
        .remaining (remaining),
        .offset    (cur_addr[1:0]),
        .op_wdata  (op_wdata),
        .lane_data (bus_wdata)
    );

    dbs_read_assemble rd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .advance    (advance),
        .op_write   (op_write),
        .op_count   (op_count),
        .remaining  (remaining),
        .step_bytes (step_bytes),
        .first_lane (first_lane),
        .bus_rdata  (bus_rdata),
        .rd_data    (rd_data)
    );

    dbs_fill_capture #(.ADDR_W(ADDR_W)) fill_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (advance),
        .op_write    (op_write),
        .op_cachable (op_cachable),
        .bus_ack     (bus_ack),
        .cur_addr    (cur_addr),
        .bus_rdata   (bus_rdata),
        .fill_valid  (fill_valid),
        .fill_addr   (fill_addr),
        .fill_mask   (fill_mask),
        .fill_data   (fill_data)
    );

    // Drive the bus-side cycle qualifiers from sequencer state
    always_comb begin
        bus_cycle     = busy;
        bus_size_code = remaining[1:0];
        bus_addr      = cur_addr;
        bus_write     = op_write;
        bus_cachable  = busy && op_cachable && !op_write;
    end

endmodule

// File: rtl/dbs_checker.sv
// Protocol checker for the dynamic bus sizing controller, bound to the top.
// Observes ports only; all properties are disabled during reset.
module dbs_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_ack,
    input logic              bus_cycle,
    input logic [1:0]        bus_size_code,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_write,
    input logic              bus_cachable,
    input logic              done,
    input logic              fill_valid,
    input logic [3:0]        fill_mask
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cycle && bus_ack == 2'b00) |=>
            (bus_cycle && $stable(bus_addr) && $stable(bus_size_code)));

    assert_byte_port_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cycle && bus_ack == 2'b01 && bus_size_code != 2'b01) |=>
            (bus_cycle && bus_size_code == $past(bus_size_code) - 2'd1
             && bus_addr == $past(bus_addr) + ONE));

    assert_last_byte_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cycle && bus_ack != 2'b00 && bus_size_code == 2'b01) |=> done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_cycle);

    assert_fill_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $past(bus_cachable && bus_ack != 2'b00));

    assert_fill_full_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cachable && bus_ack == 2'b11) |=> (fill_valid && fill_mask == 4'hF));

    assert_cachable_read_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cachable |-> (bus_cycle && !bus_write));

endmodule

bind dyn_bus_sizer dbs_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_ack       (bus_ack),
    .bus_cycle     (bus_cycle),
    .bus_size_code (bus_size_code),
    .bus_addr      (bus_addr),
    .bus_write     (bus_write),
    .bus_cachable  (bus_cachable),
    .done          (done),
    .fill_valid    (fill_valid),
    .fill_mask     (fill_mask)
);

// File: tb/dyn_bus_sizer_tb.sv
`timescale 1ns/1ps
module dyn_bus_sizer_tb_top;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              req_cachable = 1'b0;
    logic [1:0]        bus_ack = 2'b00;
    logic [31:0]       bus_rdata = '0;
    logic              bus_cycle;
    logic [1:0]        bus_size_code;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_write;
    logic [31:0]       bus_wdata;
    logic              bus_cachable;
    logic              done;
    logic [31:0]       rd_data;
    logic              fill_valid;
    logic [ADDR_W-1:0] fill_addr;
    logic [3:0]        fill_mask;
    logic [31:0]       fill_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [0:15];
    logic [7:0] ref_mem [0:15];

    always #4 clk = ~clk;

    dyn_bus_sizer #(.ADDR_W(ADDR_W)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int room_of(input int p, input int o);
        return (p == 3) ? 4 - o : (p == 2) ? 2 - (o % 2) : 1;
    endfunction

    function automatic int first_of(input int p, input int o);
        return (p == 3) ? o : (p == 2) ? (o % 2) : 0;
    endfunction

    function automatic logic [7:0] opb(input logic [31:0] d, input int n, input int j);
        return 8'(d >> (8 * (n - 1 - j)));
    endfunction

    function automatic logic [7:0] lane_of(input logic [31:0] d, input int l);
        return d[8*(3-l) +: 8];
    endfunction

    task automatic run_txn(input bit wr, input int n, input int off, input int pmode,
                           input bit cach, input int tag);
        logic [31:0] wd;
        logic [31:0] exp_rd;
        int rem;
        int cur;
        int sent;
        int cyc;
        bit waited;
        bit junk;
        wd     = 32'h9E3779B9 * 32'(tag + 1);
        exp_rd = '0;
        junk   = (tag % 5 == 0);
        for (int k = 0; k < 16; k++) begin
            mem[k]     = 8'(k * 37 + tag * 11 + 5);
            ref_mem[k] = mem[k];
        end
        for (int j = 0; j < n; j++) begin
            exp_rd = (exp_rd << 8) | 32'(mem[4 + off + j]);
            ref_mem[4 + off + j] = opb(wd, n, j);
        end
        @(negedge clk);
        req_valid    = 1'b1;
        req_write    = wr;
        req_size     = 2'(n);
        req_addr     = ADDR_W'(4 + off);
        req_wdata    = wd;
        req_cachable = cach;
        @(negedge clk);
        req_valid = 1'b0;
        rem = n; cur = 4 + off; sent = 0; cyc = 0; waited = 1'b0;
        while (rem > 0) begin
            int p, o, acc, fb, al, plen;
            logic [31:0] rdv;
            logic [3:0]  emask;
            logic [31:0] efill;
            chk(bus_cycle == 1'b1, "R2 cycle active", 32'(bus_cycle), 1);
            chk(bus_size_code == 2'(rem), "R1 size code", 32'(bus_size_code), 32'(2'(rem)));
            chk(bus_addr == ADDR_W'(cur), "R2 address", bus_addr, 32'(cur));
            chk(bus_write == wr, "R2 direction", 32'(bus_write), 32'(wr));
            chk(bus_cachable == (cach && !wr), "R12 cachable flag", 32'(bus_cachable),
                32'(cach && !wr));
            chk(done == 1'b0, "R9 no early done", 32'(done), 0);
            if (junk && cyc == 0) begin
                req_valid = 1'b1; req_write = !wr; req_size = 2'b01;
                req_addr = '0; req_cachable = !cach; req_wdata = ~wd;
            end
            if ((tag % 3 == 0) && !waited) begin
                // R3: one wait cycle, everything must hold
                waited  = 1'b1;
                bus_ack = 2'b00;
                @(negedge clk);
                req_valid = 1'b0;
                chk(fill_valid == 1'b0, "R8 no fill on wait", 32'(fill_valid), 0);
                continue;
            end
            p    = (pmode == 3) ? ((cyc + tag) % 3) + 1 : pmode + 1;
            o    = cur % 4;
            acc  = (rem < room_of(p, o)) ? rem : room_of(p, o);
            fb   = first_of(p, o);
            plen = (p == 3) ? 4 : (p == 2) ? 2 : 1;
            al   = (p == 3) ? cur - o : (p == 2) ? cur - (cur % 2) : cur;
            if (wr) begin
                for (int pw = 1; pw <= 3; pw++) begin
                    int a2;
                    a2 = (rem < room_of(pw, o)) ? rem : room_of(pw, o);
                    for (int i = 0; i < a2; i++) begin
                        chk(lane_of(bus_wdata, first_of(pw, o) + i) == opb(wd, n, sent + i),
                            "R5 write lane", 32'(lane_of(bus_wdata, first_of(pw, o) + i)),
                            32'(opb(wd, n, sent + i)));
                    end
                end
                for (int i = 0; i < acc; i++) mem[cur + i] = lane_of(bus_wdata, fb + i);
            end
            emask = '0; efill = '0;
            for (int l = 0; l < 4; l++) begin
                bit inport, accl;
                inport = (l < plen);
                accl   = (l >= fb) && (l < fb + acc);
                if (cach ? inport : accl) rdv[8*(3-l) +: 8] = mem[al + l];
                else rdv[8*(3-l) +: 8] = 8'(8'hC3 ^ (l * 29) ^ tag);
                if (inport) begin
                    emask[(al + l) % 4] = 1'b1;
                    efill[8*(3-((al + l) % 4)) +: 8] = mem[al + l];
                end
            end
            bus_rdata = rdv;
            bus_ack   = 2'(p);
            @(negedge clk);
            req_valid = 1'b0;
            bus_ack   = 2'b00;
            bus_rdata = 32'hDEADBEEF ^ 32'(tag);
            if (!wr && cach) begin
                chk(fill_valid == 1'b1, "R8 fill pulse", 32'(fill_valid), 1);
                chk(fill_addr == ADDR_W'(cur - o), "R8 fill address", fill_addr, 32'(cur - o));
                chk(fill_mask == emask, "R8 fill mask", 32'(fill_mask), 32'(emask));
                chk(fill_data == efill, "R8 fill data", fill_data, efill);
            end else begin
                chk(fill_valid == 1'b0, "R8 no fill", 32'(fill_valid), 0);
            end
            rem  -= acc;
            cur  += acc;
            sent += acc;
            cyc++;
        end
        chk(done == 1'b1, "R9 done pulse", 32'(done), 1);
        chk(bus_cycle == 1'b0, "R9 idle at done", 32'(bus_cycle), 0);
        if (wr) begin
            for (int k = 0; k < 16; k++)
                chk(mem[k] == ref_mem[k], "R4 memory image", 32'(mem[k]), 32'(ref_mem[k]));
        end else begin
            chk(rd_data == exp_rd, cach ? "R6 read operand" : "R7 noncachable operand",
                rd_data, exp_rd);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 single pulse", 32'(done), 0);
        if (junk) chk(bus_cycle == 1'b0, "R10 busy request ignored", 32'(bus_cycle), 0);
        if (!wr) chk(rd_data == exp_rd, "R9 read held", rd_data, exp_rd);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int tag;
        tag = 0;
        repeat (4) @(negedge clk);
        chk(bus_cycle == 1'b0, "R11 reset cycle", 32'(bus_cycle), 0);
        chk(done == 1'b0, "R11 reset done", 32'(done), 0);
        chk(fill_valid == 1'b0, "R11 reset fill", 32'(fill_valid), 0);
        chk(rd_data == 32'h0, "R11 reset data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_ack = 2'b11;
        @(negedge clk);
        chk(bus_cycle == 1'b0 && done == 1'b0, "R3 ack while idle ignored",
            {30'b0, bus_cycle, done}, 0);
        bus_ack = 2'b00;
        for (int wr = 0; wr < 2; wr++)
            for (int n = 1; n <= 4; n++)
                for (int off = 0; off < 4; off++)
                    for (int pm = 0; pm < 4; pm++)
                        for (int c = 0; c < 2; c++) begin
                            run_txn(wr[0], n, off, pm, c[0], tag);
                            tag++;
                        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule